// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address. It fetches one entry from a flat page table that sits in physical memory. A requester presents a virtual address and an access kind: read, write or execute. The walker adds the virtual page number, scaled by four bytes, to a table base register. It then issues a single read on a memory request port and waits for the response. Finally it decodes the returned entry.

The outcome is reported in a one-cycle completion pulse, which carries one of three results:
- a physical address made from the entry's page number and the untouched page offset;
- a not-present fault;
- a protection fault.

Software loads the base register to point the walker at the table of the process that is running. Loading it again switches the walker to another table.

Pages are 2^OFF_W bytes, which is 1 KB by default, so the low 10 address bits are the offset. Table entries are 32 bits wide and are laid out as follows:

| Bits | Field |
|------|-------|
| 31 | Present bit |
| 30:29 | Rights field |
| PPN_W-1:0 | Physical page number |
| All others | Ignored |

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `mem_req_valid`=0, `done`=0, `fault`=0 and `paddr`=0.
- R2: The memory read address is `base + vpn*4`, taken modulo 2^PA_W. Here `vpn` is `vaddr[VA_W-1:OFF_W]` and `base` is the base register value when the read is issued. Loading a different base makes later walks read a different table.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the walker keeps `mem_req_valid` high and keeps `mem_req_addr` unchanged on the next cycle.
- R4: Each accepted request produces exactly one memory read handshake. `mem_req_valid` is low when the walker is idle and after the read is accepted.
- R5: If entry bit 31 is 0, the completion reports `fault`=2'b01 (not present) with `paddr`=0.
- R6: Bits 30:29 of the entry encode the rights, and a present entry whose rights do not allow the access kind completes with `fault`=2'b10 and `paddr`=0.
  - Rights encoding: 00 = read only, 01 = read and write, 10 = execute only, 11 = no access.
  - Access kind (`req_acc`): 00 = read, 01 = write, 10 = execute, 11 = never allowed.
  - The code 2'b11 never appears on `fault`.
- R7: A present entry that permits the access completes with `fault`=2'b00 and `paddr` = {entry[PPN_W-1:0], vaddr[OFF_W-1:0]}.
- R8: `done` is high for exactly one cycle per walk, and the walker is idle with `req_ready`=1 in the cycle after it. Outside that cycle `fault` and `paddr` are 0.
- R9: A base write (`base_we`=1) is ignored while a walk is in progress. A write made while idle takes effect for the next read.
- R10: The present bit is checked before the rights. A not-present entry reports `fault`=2'b01 whatever its rights field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | PA_W | New table base address |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| paddr | output | PA_W | Physical address, 0 on a fault |
| fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The assertions rely on three things about the memory side:
- `mem_rsp_valid` rises only after a read has been accepted;
- the memory returns exactly one response per read;
- `base_we` may arrive in any state.

The memory model in the bench keeps to these rules. It answers each accepted read once, after a latency of one or two cycles. It raises ready only while a read is pending, with a stall of zero to two cycles. It also pulses `base_we` in the middle of a walk so that the ignore rule is exercised. The sweep covers every page number under every access kind, against a table based low in memory and against one whose entries wrap past the top of the address space.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W     = 32;
  localparam int PRES_BIT  = 31;
  localparam int RIGHTS_LO = 29;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_BAD   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } fault_e;

  // Which access kinds a rights code allows, as a mask indexed by kind.
  function automatic logic perm_ok(input logic [1:0] rights, input logic [1:0] acc);
    logic [3:0] allow;
    case (rights)
      2'b00:   allow = 4'b0001;  // read only
      2'b01:   allow = 4'b0011;  // read and write
      2'b10:   allow = 4'b0100;  // execute only
      default: allow = 4'b0000;  // no access
    endcase
    return allow[acc];
  endfunction
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            idle,
  output logic [PA_W-1:0] base_q
);
  logic wr_take;
  assign wr_take = wr_en && idle;

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_take) base_q <= wr_data;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic st_idle,
  output logic st_issue,
  output logic st_wait,
  output logic st_check
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_CHECK} st_e;
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (req_valid)     st_d = S_ISSUE;
      S_ISSUE: if (mem_req_ready) st_d = S_WAIT;
      S_WAIT:  if (mem_rsp_valid) st_d = S_CHECK;
      default:                    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign st_idle  = (st_q == S_IDLE);
  assign st_issue = (st_q == S_ISSUE);
  assign st_wait  = (st_q == S_WAIT);
  assign st_check = (st_q == S_CHECK);
endmodule

// File: rtl/ptw_check.sv
module ptw_check #(
  parameter int PPN_W = 6,
  parameter int OFF_W = 10,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             present,
  input  logic [1:0]       rights,
  input  logic [PPN_W-1:0] ppn,
  input  logic [1:0]       acc,
  input  logic [OFF_W-1:0] offset,
  output logic [1:0]       fault,
  output logic [PA_W-1:0]  paddr
);
  import ptw_pkg::*;

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!present)                   fault = FLT_PAGE;
    else if (!perm_ok(rights, acc)) fault = FLT_PROT;
    else                            paddr = {ppn, offset};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 16,
  parameter int OFF_W = 10,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_we,
  input  logic [PA_W-1:0]         base_wdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_acc,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ptw_pkg::PTE_W-1:0] mem_rsp_data,
  output logic                    done,
  output logic [PA_W-1:0]         paddr,
  output logic [1:0]              fault
);
  import ptw_pkg::*;

  // Entry byte address: base plus page number scaled to 4-byte entries.
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [VPN_W-1:0] vpn);
    logic [PA_W+1:0] scaled;
    scaled = (PA_W+2)'(vpn) << 2;
    return base + scaled[PA_W-1:0];
  endfunction

  logic st_idle, st_issue, st_wait, st_check;
  logic [PA_W-1:0] base_q;
  logic [VA_W-1:0] va_q;
  logic [1:0] acc_q;
  logic pres_q;
  logic [1:0] rights_q;
  logic [PPN_W-1:0] ppn_q;
  logic req_fire, rsp_take;
  logic [1:0] chk_fault;
  logic [PA_W-1:0] chk_paddr;

  assign req_fire = req_valid && st_idle;
  assign rsp_take = mem_rsp_valid && st_wait;

  ptw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .st_idle(st_idle), .st_issue(st_issue), .st_wait(st_wait), .st_check(st_check)
  );

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_we), .wr_data(base_wdata),
    .idle(st_idle), .base_q(base_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q  <= '0;
      acc_q <= ACC_READ;
    end else if (req_fire) begin
      va_q  <= req_vaddr;
      acc_q <= req_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q   <= 1'b0;
      rights_q <= '0;
      ppn_q    <= '0;
    end else if (rsp_take) begin
      pres_q   <= mem_rsp_data[PRES_BIT];
      rights_q <= mem_rsp_data[RIGHTS_LO +: 2];
      ppn_q    <= mem_rsp_data[PPN_W-1:0];
    end
  end

  ptw_check #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
    .present(pres_q), .rights(rights_q), .ppn(ppn_q), .acc(acc_q),
    .offset(va_q[OFF_W-1:0]), .fault(chk_fault), .paddr(chk_paddr)
  );

  assign req_ready     = st_idle;
  assign mem_req_valid = st_issue;
  assign mem_req_addr  = entry_addr(base_q, va_q[VA_W-1:OFF_W]);
  assign done          = st_check;
  assign fault         = st_check ? chk_fault : 2'b00;
  assign paddr         = st_check ? chk_paddr : '0;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic [1:0]      fault,
  input logic [PA_W-1:0] paddr,
  input logic            base_we,
  input logic [PA_W-1:0] base_q
);
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && mem_req_addr == $past(mem_req_addr)));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !done));

  p_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_fault_zero_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'b00) |-> (paddr == '0));

  p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault != 2'b11);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (fault == 2'b00 && paddr == '0));

  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && base_we) |=> (base_q == $past(base_q)));
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) u_ptw_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .done(done),
  .fault(fault), .paddr(paddr), .base_we(base_we), .base_q(base_q)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_vaddr = '0;
  logic [1:0] req_acc = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done;
  logic [15:0] paddr;
  logic [1:0] fault;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_addr = '0;
  int stall_cfg = 0;
  int lat_cfg = 1;
  int reads = 0;

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .paddr(paddr), .fault(fault)
  );

  // Table contents as a pure function of the entry address.
  function automatic logic [31:0] table_word(input logic [15:0] a);
    int idx, pr, rt, pp;
    idx = int'(a) / 4;
    pr = ((idx % 5) != 3) ? 1 : 0;
    rt = (idx / 3) % 4;
    pp = (idx * 11 + 5) % 64;
    return {pr[0], rt[1:0], 23'h2A5A5, pp[5:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: answers on negedges.
  initial begin : mem_model
    bit fire_pend = 1'b0;
    int stall_left = 0;
    int lat_cnt = 0;
    logic [15:0] hold_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (fire_pend) begin
        fire_pend = 1'b0;
        mem_req_ready = 1'b0;
        reads++;
        lat_cnt = lat_cnt + lat_cfg;
        chk(!mem_req_valid, "R4", "request dropped after accept", 32'(mem_req_valid), 0);
      end
      if (lat_cnt > 0) begin
        lat_cnt--;
        if (lat_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = table_word(hold_addr);
        end
      end
      if (mem_req_valid) begin
        chk(mem_req_addr == exp_addr, "R2 R3", "entry address", 32'(mem_req_addr), 32'(exp_addr));
        if (!mem_req_ready && stall_left == 0) stall_left = stall_cfg + 1;
        stall_left--;
        if (stall_left == 0) begin
          mem_req_ready = 1'b1;
          fire_pend = 1'b1;
          hold_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic set_base(input logic [15:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic walk(input logic [15:0] base, input logic [15:0] va, input logic [1:0] acc,
                      input bit poke_base);
    logic [15:0] ea, exp_pa;
    logic [31:0] w;
    logic [1:0] exp_f;
    bit allow;
    string req;
    int n;
    ea = base + 16'(int'(va[15:10]) * 4);
    w = table_word(ea);
    allow = (acc == 2'd0 && w[30:29] <= 2'd1) || (acc == 2'd1 && w[30:29] == 2'd1) ||
            (acc == 2'd2 && w[30:29] == 2'd2);
    if (!w[31]) begin
      exp_f = 2'b01; exp_pa = 0; req = allow ? "R5" : "R10";
    end else if (!allow) begin
      exp_f = 2'b10; exp_pa = 0; req = "R6";
    end else begin
      exp_f = 2'b00; exp_pa = {w[5:0], va[9:0]}; req = "R7";
    end
    @(negedge clk);
    exp_addr = ea;
    reads = 0;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "busy after accept", 32'(req_ready), 0);
    if (poke_base) begin
      base_we = 1'b1; base_wdata = 16'h0123;
      @(negedge clk);
      base_we = 1'b0;
    end
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8", "completion seen", 32'(done), 1);
    chk(fault == exp_f && paddr == exp_pa, req, "fault,paddr",
        {14'd0, fault, paddr}, {14'd0, exp_f, exp_pa});
    chk(reads == 1, "R4", "reads per walk", 32'(reads), 1);
    @(negedge clk);
    chk(!done && req_ready && fault == 0 && paddr == 0, "R8", "done,ready after pulse",
        {30'd0, done, req_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] bases [2];
    bases[0] = 16'h1000;
    bases[1] = 16'hFFC0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !done && fault == 0 && paddr == 0, "R1", "reset outputs",
        {27'd0, req_ready, mem_req_valid, done, fault}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done, "R1", "idle after reset",
        {29'd0, req_ready, mem_req_valid, done}, 32'h4);
    for (int b = 0; b < 2; b++) begin
      set_base(bases[b]);
      for (int v = 0; v < 64; v++) begin
        for (int a = 0; a < 4; a++) begin
          stall_cfg = (v + a) % 3;
          lat_cfg = 1 + (v % 2);
          walk(bases[b], {v[5:0], 10'((v * 37 + a * 101) % 1024)}, a[1:0], 1'b0);
        end
      end
    end
    // R9: a base write during a walk leaves the old base in place.
    walk(bases[1], 16'h0C00, 2'd0, 1'b1);
    walk(bases[1], 16'h1555, 2'd1, 1'b0);
    // R9: a write while idle takes effect at once.
    set_base(16'h2200);
    walk(16'h2200, 16'h1555, 2'd1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule